// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog timer with a small register port. A prescaler derives a count tick from the block clock, nominally 33 MHz, dividing by a fast factor (about 1 MHz) or a slow factor (about 1 kHz). Once enabled, the timer counts down a first-stage preload. When that stage expires it may raise an interrupt, and it then counts down a second-stage preload. When the second stage expires the block emits a one-cycle system reset pulse and sets a sticky timeout flag. The flag is cleared only by the block's own power-on reset or by an explicit clear from software.

The two preload registers and the reload/status register are protected. A write to one of them takes effect only when it directly follows a write of 0x80 and then a write of 0x86 to the reload register. The configuration register and the enable register are not protected. A read-only status register shows the live count, the active stage and the enable state.

Register offsets: 0 reload/status, 1 first preload, 2 second preload, 3 configuration, 4 enable, 5 live status.

Top module: `twin_stage_wdog`

## Requirements
- R1: A write to offset 0, 1 or 2 changes state only if the two accesses just before it were a write of 0x80 to offset 0 and then a write of 0x86 to offset 0; without that sequence the write is ignored.
- R2: Any access between or after the two unlock writes that is not the next expected step returns the sequence to idle. This includes a read, a write to offset 3, or a wrong value. A protected write that follows a broken sequence is ignored.
- R3: Configuration bit 0 selects the tick divide: 1 gives DIV_FAST clock cycles per tick, 0 gives DIV_SLOW.
- R4: After enable, the first stage counts down from the offset-1 preload P once per tick and expires on the tick that finds the count at zero, i.e. P+1 ticks after enable. The second stage then loads the offset-2 preload Q and expires Q+1 ticks later.
- R5: On first-stage expiry irq_o is set unless configuration bits [2:1] equal 2'b11. Once set, irq_o stays high until a reload, a disable or a second-stage expiry.
- R6: Second-stage expiry drives wdt_rst_o high for exactly one cycle, sets the timeout flag (offset 0 bit 9), and restarts the first stage.
- R7: The timeout flag is cleared only by rst_ni or by an unlocked write to offset 0 with bit 9 set. Its own reset pulse and unlocked writes with bit 9 clear leave it set.
- R8: An unlocked write to offset 0 with bit 8 set restarts the first stage from P, restarts the prescaler and clears irq_o. It takes priority over a second-stage expiry in the same cycle, so no pulse is emitted.
- R9: Offset 4 bit 0 enables the timer. While it is 0 the prescaler is held, the count stays at P in stage one, and no irq or reset pulse is produced.
- R10: A read of offset 5 returns the count in bits [CNT_W-1:0], the active stage (1 = second) in bit 30, and the enable in bit 31.
- R11: After rst_ni the outputs are low, the enable, flag and configuration are 0, the first preload reads all ones and the second preload reads 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the tick source |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of req_i |
| irq_o | output | 1 | First-stage interrupt, level |
| wdt_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The delicate coincidence is a software reload landing in the same cycle as the tick that expires the second stage. The bench times the final write of an unlock-plus-reload sequence to land on exactly that clock edge, then confirms at the pins that no reset pulse appears. It also confirms that the next pulse comes one full first-plus-second-stage period after the reload. Sweeps over prescaler, first preload and second preload check the exact cycles at which irq_o and wdt_rst_o first appear against cycle counts computed from the requirements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {LK_IDLE, LK_HALF, LK_OPEN} lock_e;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_0080;
  localparam logic [31:0] KEY_SECOND = 32'h0000_0086;

  localparam logic [2:0] OFS_RELOAD = 3'd0;
  localparam logic [2:0] OFS_PRE1   = 3'd1;
  localparam logic [2:0] OFS_PRE2   = 3'd2;
  localparam logic [2:0] OFS_CFG    = 3'd3;
  localparam logic [2:0] OFS_EN     = 3'd4;
  localparam logic [2:0] OFS_STAT   = 3'd5;

  localparam int RLD_BIT = 8;
  localparam int TMO_BIT = 9;
  localparam logic [1:0] IRQ_OFF = 2'b11;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          open_o
);
  lock_e state_q;
  logic  wr_reload;

  assign wr_reload = req_i && we_i && (addr_i == AW'(OFS_RELOAD));
  assign open_o    = (state_q == LK_OPEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_IDLE;
    end else if (req_i) begin
      // any access off the expected path drops back to idle
      if (wr_reload && state_q != LK_OPEN && wdata_i == DW'(KEY_FIRST))
        state_q <= LK_HALF;
      else if (wr_reload && state_q == LK_HALF && wdata_i == DW'(KEY_SECOND))
        state_q <= LK_OPEN;
      else
        state_q <= LK_IDLE;
    end
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fast_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (DIV_SLOW > DIV_FAST) ? $clog2(DIV_SLOW) : $clog2(DIV_FAST);

  logic [PW-1:0] pc_q;
  logic [PW-1:0] lim;

  assign lim    = fast_i ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  assign tick_o = en_i && (pc_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pc_q <= '0;
    else if (!en_i || restart_i) pc_q <= '0;
    else if (pc_q >= lim)        pc_q <= '0;
    else                         pc_q <= pc_q + PW'(1);
  end
endmodule

// File: rtl/wdog_stages.sv
module wdog_stages #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic             irq_allow_i,
  input  logic [CNT_W-1:0] pre1_i,
  input  logic [CNT_W-1:0] pre2_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             stage_o,
  output logic             irq_o,
  output logic             exp2_o,
  output logic             rst_pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             stage_q, irq_q, pulse_q;
  logic             at_zero, exp1;

  assign at_zero = (cnt_q == '0);
  assign exp1    = en_i && !reload_i && tick_i && at_zero && !stage_q;
  assign exp2_o  = en_i && !reload_i && tick_i && at_zero && stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= 1'b0;
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= exp2_o;
      if (!en_i || reload_i) begin
        cnt_q   <= pre1_i;
        stage_q <= 1'b0;
        irq_q   <= 1'b0;
      end else if (exp1) begin
        cnt_q   <= pre2_i;
        stage_q <= 1'b1;
        if (irq_allow_i) irq_q <= 1'b1;
      end else if (exp2_o) begin
        cnt_q   <= pre1_i;
        stage_q <= 1'b0;
        irq_q   <= 1'b0;
      end else if (tick_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign stage_o     = stage_q;
  assign irq_o       = irq_q;
  assign rst_pulse_o = pulse_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             open_i,
  input  logic             exp2_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             stage_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CNT_W-1:0] pre1_o,
  output logic [CNT_W-1:0] pre2_o,
  output logic             fast_o,
  output logic [1:0]       mode_o,
  output logic             en_o,
  output logic             tmo_o,
  output logic             tmo_clr_o,
  output logic             reload_o
);
  localparam int PADW = DW - 2 - CNT_W;

  logic wr, pwr;
  logic tmo_q, en_q, fast_q;
  logic [1:0] mode_q;
  logic [CNT_W-1:0] pre1_q, pre2_q;

  assign wr        = req_i && we_i;
  assign pwr       = wr && open_i;
  assign reload_o  = pwr && (addr_i == AW'(OFS_RELOAD)) && wdata_i[RLD_BIT];
  assign tmo_clr_o = pwr && (addr_i == AW'(OFS_RELOAD)) && wdata_i[TMO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre1_q <= '1;
      pre2_q <= CNT_W'(2);
    end else begin
      if (pwr && addr_i == AW'(OFS_PRE1)) pre1_q <= wdata_i[CNT_W-1:0];
      if (pwr && addr_i == AW'(OFS_PRE2)) pre2_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= 1'b0;
      mode_q <= 2'b00;
      en_q   <= 1'b0;
    end else begin
      if (wr && addr_i == AW'(OFS_CFG)) begin
        fast_q <= wdata_i[0];
        mode_q <= wdata_i[2:1];
      end
      if (wr && addr_i == AW'(OFS_EN)) en_q <= wdata_i[0];
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tmo_q <= 1'b0;
    else if (exp2_i)    tmo_q <= 1'b1;
    else if (tmo_clr_o) tmo_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFS_RELOAD): rdata_o[TMO_BIT] = tmo_q;
      AW'(OFS_PRE1):   rdata_o[CNT_W-1:0] = pre1_q;
      AW'(OFS_PRE2):   rdata_o[CNT_W-1:0] = pre2_q;
      AW'(OFS_CFG):    rdata_o[2:0] = {mode_q, fast_q};
      AW'(OFS_EN):     rdata_o[0] = en_q;
      AW'(OFS_STAT):   rdata_o = {en_q, stage_i, {PADW{1'b0}}, cnt_i};
      default:         rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign pre1_o = pre1_q;
  assign pre2_o = pre2_q;
  assign fast_o = fast_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign tmo_o  = tmo_q;
endmodule

// File: rtl/twin_stage_wdog.sv
module twin_stage_wdog
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 32768
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        wdt_rst_o
);
  localparam int AW = 3;
  localparam int DW = 32;

  logic             lk_open, tick, exp2, reload, tmo_q, tmo_clr;
  logic             en_q, fast_q, stage_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] pre1_q, pre2_q, cnt_q;

  wdog_unlock #(.AW(AW), .DW(DW)) u_unlock (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .open_o(lk_open)
  );

  wdog_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .open_i(lk_open), .exp2_i(exp2), .cnt_i(cnt_q), .stage_i(stage_q),
    .rdata_o, .pre1_o(pre1_q), .pre2_o(pre2_q), .fast_o(fast_q),
    .mode_o(mode_q), .en_o(en_q), .tmo_o(tmo_q), .tmo_clr_o(tmo_clr),
    .reload_o(reload)
  );

  wdog_prescale #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk_i, .rst_ni, .en_i(en_q), .fast_i(fast_q), .restart_i(reload),
    .tick_o(tick)
  );

  wdog_stages #(.CNT_W(CNT_W)) u_stages (
    .clk_i, .rst_ni, .en_i(en_q), .tick_i(tick), .reload_i(reload),
    .irq_allow_i(mode_q != IRQ_OFF), .pre1_i(pre1_q), .pre2_i(pre2_q),
    .cnt_o(cnt_q), .stage_o(stage_q), .irq_o(irq_o), .exp2_o(exp2),
    .rst_pulse_o(wdt_rst_o)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             irq_o,
  input logic             wdt_rst_o,
  input logic             tmo_q,
  input logic             tmo_clr,
  input logic             en_q,
  input logic             stage_q,
  input logic             lk_open,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] pre1_q
);
  p_pre1_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pre1_q) |-> $past(lk_open && req_i && we_i));

  p_exp_from_stage2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(stage_q) && !stage_q);

  p_irq_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(mode_q) != 2'b11);

  p_pulse_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  p_pulse_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> tmo_q);

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q && !tmo_clr |=> tmo_q);

  p_disabled_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !wdt_rst_o && !$rose(irq_o));
endmodule

bind twin_stage_wdog wdog_checker #(.CNT_W(CNT_W)) u_wdog_checker (
  .clk_i, .rst_ni, .req_i, .we_i, .irq_o, .wdt_rst_o, .tmo_q, .tmo_clr,
  .en_q, .stage_q, .lk_open, .mode_q, .pre1_q
);

// File: tb/test_twin_stage_wdog.sv
`timescale 1ns/1ps
module test_twin_stage_wdog;
  localparam int CW = 8, DF = 4, DS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wrst;
  int checks = 0, errors = 0, rst_seen = 0;

  always #2.5 clk = ~clk;

  twin_stage_wdog #(.CNT_W(CW), .DIV_FAST(DF), .DIV_SLOW(DS)) i_twin_stage_wdog (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst)
  );

  always @(negedge clk) if (wrst) rst_seen++;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic uwr(logic [2:0] a, logic [31:0] d);
    wr(3'd0, 32'h80); wr(3'd0, 32'h86); wr(a, d);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base, irq_k, rst_k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 0);
    chk("R11 rst", {31'b0, wrst}, 0);
    rd(3'd0, d); chk("R11 flag", d, 0);
    rd(3'd1, d); chk("R11 pre1", d, 32'hFF);
    rd(3'd2, d); chk("R11 pre2", d, 2);
    rd(3'd4, d); chk("R11 en", d, 0);
    // R1 unlocked vs plain protected writes
    wr(3'd1, 32'h05); rd(3'd1, d); chk("R1 plain write ignored", d, 32'hFF);
    uwr(3'd1, 32'h05); rd(3'd1, d); chk("R1 unlocked write", d, 5);
    // R2 broken sequences
    wr(3'd0, 32'h80); rd(3'd3, d); wr(3'd0, 32'h86); wr(3'd1, 32'h09);
    rd(3'd1, d); chk("R2 read breaks unlock", d, 5);
    wr(3'd0, 32'h80); wr(3'd3, 0); wr(3'd0, 32'h86); wr(3'd2, 32'h07);
    rd(3'd2, d); chk("R2 cfg write breaks unlock", d, 2);
    wr(3'd0, 32'h86); wr(3'd0, 32'h80); wr(3'd2, 32'h07);
    rd(3'd2, d); chk("R2 wrong order", d, 2);
    wr(3'd0, 32'h200); rd(3'd0, d); chk("R2 plain flag clear ignored", d, 0);

    // R3/R4/R5/R6 sweep
    for (int sel = 0; sel < 2; sel++)
      for (int p = 0; p < 4; p++)
        for (int q = 0; q < 3; q++) begin
          int dv;
          dv = sel ? DF : DS;
          wr(3'd4, 0); wr(3'd3, sel);
          uwr(3'd1, p); uwr(3'd2, q);
          base = rst_seen; irq_k = 0; rst_k = 0;
          wr(3'd4, 1);
          for (int k = 1; k < 2000 && rst_k == 0; k++) begin
            @(negedge clk);
            if (irq && irq_k == 0) irq_k = k;
            if (wrst) begin rst_k = k; chk("R6 irq dropped at pulse", {31'b0, irq}, 0); end
          end
          chk("R3 R5 irq cycle", irq_k, dv * (p + 1));
          chk("R4 pulse cycle", rst_k, dv * (p + q + 2));
          @(negedge clk);
          chk("R6 one-cycle pulse", rst_seen - base, 1);
        end
    wr(3'd4, 0);
    rd(3'd0, d); chk("R6 flag set", d, 32'h200);
    uwr(3'd0, 32'h000); rd(3'd0, d); chk("R7 flag kept on bit9=0", d, 32'h200);
    uwr(3'd0, 32'h200); rd(3'd0, d); chk("R7 flag cleared", d, 0);

    // R5 interrupt suppressed
    wr(3'd3, 32'h7); uwr(3'd1, 1); uwr(3'd2, 1);
    base = rst_seen; irq_k = 0; rst_k = 0;
    wr(3'd4, 1);
    for (int k = 1; k < 200 && rst_k == 0; k++) begin
      @(negedge clk);
      if (irq) irq_k++;
      if (wrst) rst_k = k;
    end
    chk("R5 irq masked", irq_k, 0);
    chk("R5 pulse still at cycle", rst_k, DF * 4);
    wr(3'd4, 0);
    uwr(3'd0, 32'h200);

    // R8 reload collides with second-stage expiry at edge 20
    wr(3'd3, 32'h1); uwr(3'd1, 3); uwr(3'd2, 0);
    base = rst_seen;
    wr(3'd4, 1);
    repeat (DF * 5 - 3) @(negedge clk);
    chk("R8 irq high before reload", {31'b0, irq}, 1);
    uwr(3'd0, 32'h100);
    chk("R8 no pulse on collision", rst_seen - base, 0);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    rst_k = 0;
    for (int k = 1; k < 200 && rst_k == 0; k++) begin
      @(negedge clk);
      if (wrst) rst_k = k;
    end
    chk("R8 full period after reload", rst_k, DF * 5);
    rd(3'd0, d); chk("R7 flag set by later pulse", d, 32'h200);
    wr(3'd4, 0);

    // R10 status readback
    uwr(3'd1, 3); wr(3'd4, 1);
    repeat (6) @(negedge clk);
    rd(3'd5, d); chk("R10 stage1 status", d, 32'h8000_0002);
    wr(3'd4, 0); uwr(3'd1, 0); uwr(3'd2, 2); wr(3'd4, 1);
    repeat (5) @(negedge clk);
    rd(3'd5, d); chk("R10 stage2 status", d, 32'hC000_0002);

    // R9 disable stops the timer
    wr(3'd4, 0); uwr(3'd1, 1); uwr(3'd2, 0);
    base = rst_seen;
    wr(3'd4, 1); repeat (5) @(negedge clk);
    wr(3'd4, 0); repeat (100) @(negedge clk);
    chk("R9 no pulse when disabled", rst_seen - base, 0);
    chk("R9 irq low when disabled", {31'b0, irq}, 0);
    rd(3'd5, d); chk("R9 held at preload", d, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule